// File: doc/BRIEF.md
# Two-Thread Partitioned Dispatch Queue

This block is an instruction dispatch queue that two hardware threads share. Each thread writes through its own enqueue port. A single dequeue port serves both threads. Every stored entry carries the number of the thread that wrote it. Within one thread, entries leave in the order they arrived. Between threads, the dequeue port takes turns. When only one thread has entries, the port serves that thread.

Capacity depends on how many threads are running. With both threads active, neither thread may grow past half the entries. With a single thread active, that thread may fill the whole structure, so a lone thread runs as it would with a private queue. An inactive thread keeps whatever it already holds. The cap is checked only when a new entry is written, so nothing is ever discarded when the active set changes. A per-thread flush, used after a trap or a mispredicted branch, removes every entry of one thread in a single cycle. The other thread's entries and their order are left as they were.

Top module: `smt_dispatch_queue`

## Requirements
- R1: After reset both `empty` bits are 1, `deq_valid` is 0, and `full[t]` equals the inverse of `thread_active[t]`.
- R2: While both threads are active, `full[t]` is 1 when thread t holds at least DEPTH/2 entries. An enqueue offered while `full[t]` is 1 is not stored.
- R3: With exactly one thread active, that thread can store up to DEPTH entries. Its `full` bit rises when its own count or the total count reaches DEPTH.
- R4: An inactive thread always reads `full` = 1, and its enqueues are ignored.
- R5: Entries of one thread leave the dequeue port in the order they were accepted.
- R6: When both threads hold entries, the dequeue port offers the thread other than the one served last. The thread served last is taken as thread 1 after reset, so thread 0 goes first. When only one thread holds entries, the port offers that thread.
- R7: `deq_tid` (0 or 1) names the thread of the offered entry. `deq_valid` is 0 when no thread holds an entry, and a `deq_req` then changes nothing.
- R8: Asserting `flush[t]` for one cycle leaves thread t empty in the next cycle. The other thread's entries and their order stay unchanged.
- R9: In a cycle where `flush[t]` is 1, thread t is not offered on the dequeue port, and an enqueue from thread t is dropped.
- R10: A change in `thread_active` removes no entries. A thread that holds more than its new cap keeps them, and its `full` bit stays 1 until its count falls below the cap.
- R11: Both threads can each have one entry accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_active | input | 2 | Bit t set when thread t is running |
| enq_valid | input | 2 | Per-thread enqueue request |
| enq_data | input | 2 x DATA_W | Per-thread enqueue payload, thread t in slice t |
| flush | input | 2 | Per-thread flush of all stored entries |
| deq_req | input | 1 | Consume the offered entry |
| deq_valid | output | 1 | An entry is offered |
| deq_tid | output | 1 | Thread of the offered entry |
| deq_data | output | DATA_W | Payload of the offered entry |
| full | output | 2 | Per-thread: enqueue would be refused |
| empty | output | 2 | Per-thread: holds no entries |

## Verification
The bench builds the block with DEPTH = 8 and DATA_W = 12. With these values the half cap of four and the full capacity of eight are reached within a few cycles. That makes the cap switch on activation changes, the total-occupancy limit with a stranded inactive thread, and flushes of nearly full partitions easy to drive many times. A random phase mixes activation changes, rare flushes and dequeues against a queue-based model. In that phase compaction after removals from the middle of the array happens often.

// File: rtl/smt_dq_pkg.sv
package smt_dq_pkg;
    localparam int NTHR = 2;
    typedef logic tid_t;
endpackage

// File: rtl/smt_dq_oldest.sv
module smt_dq_oldest #(
    parameter int   DEPTH  = 16,
    parameter logic THREAD = 1'b0
) (
    input  logic [DEPTH-1:0]         vld,
    input  logic [DEPTH-1:0]         tid,
    output logic                     found,
    output logic [$clog2(DEPTH)-1:0] idx
);
    localparam int IDX_W = $clog2(DEPTH);

    // lowest slot is oldest; scan downward so the lowest match wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vld[i] && (tid[i] == THREAD)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/smt_dq_rr.sv
module smt_dq_rr
    import smt_dq_pkg::*;
(
    input  logic [NTHR-1:0] has,
    input  tid_t            last,
    output logic            valid,
    output tid_t            sel
);
    always_comb begin
        valid = |has;
        if (has[0] && has[1]) sel = ~last;
        else                  sel = has[1];
    end
endmodule

// File: rtl/smt_dispatch_queue.sv
module smt_dispatch_queue
    import smt_dq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 thread_active,
    input  logic [1:0]                 enq_valid,
    input  logic [1:0][DATA_W-1:0]     enq_data,
    input  logic [1:0]                 flush,
    input  logic                       deq_req,
    output logic                       deq_valid,
    output logic                       deq_tid,
    output logic [DATA_W-1:0]          deq_data,
    output logic [1:0]                 full,
    output logic [1:0]                 empty
);
    localparam int HALF  = DEPTH / 2;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0]             tid;
        logic [DEPTH-1:0][DATA_W-1:0] dat;
        logic [NTHR-1:0][CNT_W-1:0]   cnt;
        tid_t                         last;
    } state_t;

    state_t st_q, st_d;

    logic [NTHR-1:0]            found;
    logic [NTHR-1:0][IDX_W-1:0] old_idx;
    logic [NTHR-1:0]            has;
    logic [NTHR-1:0]            acc;
    logic [CNT_W-1:0]           limit;
    logic [CNT_W:0]             total;
    logic                       deq_fire;
    logic [IDX_W-1:0]           deq_idx;

    // signals observed by the bound checker
    logic [DEPTH-1:0]           occ_vld;
    logic [DEPTH-1:0]           occ_tid;
    logic [CNT_W-1:0]           occ_cnt0;
    logic [CNT_W-1:0]           occ_cnt1;

    genvar t;
    generate
        for (t = 0; t < NTHR; t++) begin : g_thr
            smt_dq_oldest #(.DEPTH(DEPTH), .THREAD(1'(t))) u_oldest (
                .vld   (st_q.vld),
                .tid   (st_q.tid),
                .found (found[t]),
                .idx   (old_idx[t])
            );
            assign has[t]   = found[t] & ~flush[t];
            assign empty[t] = (st_q.cnt[t] == '0);
            assign full[t]  = ~thread_active[t]
                            | (st_q.cnt[t] >= limit)
                            | (total >= (CNT_W + 1)'(DEPTH));
            assign acc[t]   = enq_valid[t] & ~full[t] & ~flush[t];
        end
    endgenerate

    assign limit = (&thread_active) ? CNT_W'(HALF) : CNT_W'(DEPTH);
    assign total = {1'b0, st_q.cnt[0]} + {1'b0, st_q.cnt[1]};

    smt_dq_rr u_rr (
        .has   (has),
        .last  (st_q.last),
        .valid (deq_valid),
        .sel   (deq_tid)
    );

    assign deq_idx  = old_idx[deq_tid];
    assign deq_data = st_q.dat[deq_idx];
    assign deq_fire = deq_req & deq_valid;

    always_comb begin
        int unsigned n;
        logic        keep;
        st_d      = '0;
        st_d.last = deq_fire ? deq_tid : st_q.last;
        n         = 0;
        // compact survivors toward slot 0, preserving age order
        for (int i = 0; i < DEPTH; i++) begin
            keep = st_q.vld[i] & ~flush[st_q.tid[i]]
                 & ~(deq_fire && (IDX_W'(i) == deq_idx));
            if (keep && (n < DEPTH)) begin
                st_d.vld[IDX_W'(n)] = 1'b1;
                st_d.tid[IDX_W'(n)] = st_q.tid[i];
                st_d.dat[IDX_W'(n)] = st_q.dat[i];
                n = n + 1;
            end
        end
        // append accepted writes behind the survivors, thread 0 first
        for (int k = 0; k < NTHR; k++) begin
            if (acc[k] && (n < DEPTH)) begin
                st_d.vld[IDX_W'(n)] = 1'b1;
                st_d.tid[IDX_W'(n)] = 1'(k);
                st_d.dat[IDX_W'(n)] = enq_data[k];
                n = n + 1;
            end
        end
        for (int k = 0; k < NTHR; k++) begin
            if (flush[k]) st_d.cnt[k] = '0;
            else          st_d.cnt[k] = st_q.cnt[k] + CNT_W'(acc[k])
                                      - CNT_W'(deq_fire && (deq_tid == 1'(k)));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.last <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign occ_vld  = st_q.vld;
    assign occ_tid  = st_q.tid;
    assign occ_cnt0 = st_q.cnt[0];
    assign occ_cnt1 = st_q.cnt[1];
endmodule

// File: rtl/smt_dq_checker.sv
module smt_dq_checker #(
    parameter int DEPTH = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [1:0]                   thread_active,
    input logic [1:0]                   enq_valid,
    input logic [1:0]                   flush,
    input logic                         deq_req,
    input logic                         deq_valid,
    input logic                         deq_tid,
    input logic [1:0]                   full,
    input logic [1:0]                   empty,
    input logic [DEPTH-1:0]             occ_vld,
    input logic [DEPTH-1:0]             occ_tid,
    input logic [$clog2(DEPTH+1)-1:0]   occ_cnt0,
    input logic [$clog2(DEPTH+1)-1:0]   occ_cnt1
);
    logic seen_q;
    logic served_q;
    logic fire0;
    logic fire1;

    assign fire0 = deq_req & deq_valid & ~deq_tid;
    assign fire1 = deq_req & deq_valid & deq_tid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q   <= 1'b0;
            served_q <= 1'b0;
        end else if (deq_req && deq_valid) begin
            seen_q   <= 1'b1;
            served_q <= deq_tid;
        end
    end

    assert_cap_hold_t0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (&thread_active && enq_valid[0] && full[0] && !fire0) |=> (occ_cnt0 <= $past(occ_cnt0)));
    assert_cap_hold_t1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (&thread_active && enq_valid[1] && full[1] && !fire1) |=> (occ_cnt1 <= $past(occ_cnt1)));
    assert_total_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, occ_cnt0} + {1'b0, occ_cnt1} <= DEPTH));
    assert_idle_no_growth_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!thread_active[1] && !fire1) |=> (occ_cnt1 <= $past(occ_cnt1)));
    assert_take_turns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && !empty[0] && !empty[1] && flush == 2'b00 && seen_q) |-> (deq_tid != served_q));
    assert_offer_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        deq_valid |-> !empty[deq_tid]);
    assert_flush_clears_t0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush[0] |=> empty[0]);
    assert_flush_clears_t1_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush[1] |=> empty[1]);
    assert_flush_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush == 2'b01 && !enq_valid[1] && !fire1) |=> (occ_cnt1 == $past(occ_cnt1)));
    assert_count_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(occ_vld & occ_tid) == occ_cnt1) && ($countones(occ_vld & ~occ_tid) == occ_cnt0));
endmodule

bind smt_dispatch_queue smt_dq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .thread_active (thread_active),
    .enq_valid     (enq_valid),
    .flush         (flush),
    .deq_req       (deq_req),
    .deq_valid     (deq_valid),
    .deq_tid       (deq_tid),
    .full          (full),
    .empty         (empty),
    .occ_vld       (occ_vld),
    .occ_tid       (occ_tid),
    .occ_cnt0      (occ_cnt0),
    .occ_cnt1      (occ_cnt1)
);

// File: tb/smt_dispatch_queue_bench.sv
`timescale 1ns/1ps
module smt_dispatch_queue_bench;
    localparam int DEPTH  = 8;
    localparam int DATA_W = 12;
    localparam int HALF   = DEPTH / 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                   rst_n;
    logic [1:0]             thread_active;
    logic [1:0]             enq_valid;
    logic [1:0][DATA_W-1:0] enq_data;
    logic [1:0]             flush;
    logic                   deq_req;
    logic                   deq_valid;
    logic                   deq_tid;
    logic [DATA_W-1:0]      deq_data;
    logic [1:0]             full;
    logic [1:0]             empty;

    smt_dispatch_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_smt_dispatch_queue (
        .clk(clk), .rst_n(rst_n), .thread_active(thread_active),
        .enq_valid(enq_valid), .enq_data(enq_data), .flush(flush),
        .deq_req(deq_req), .deq_valid(deq_valid), .deq_tid(deq_tid),
        .deq_data(deq_data), .full(full), .empty(empty)
    );

    int    total_checks = 0;
    int    bad = 0;
    string cur_req = "R1";

    // reference model: one queue per thread
    logic [DATA_W-1:0] mq0[$];
    logic [DATA_W-1:0] mq1[$];
    logic              m_last;
    logic [1:0]        e_full;
    logic              e_valid;
    logic              e_tid;
    int                seq = 0;

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        total_checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        int  sz[2];
        int  lim;
        logic [1:0] hs;
        logic [DATA_W-1:0] ed;
        sz[0] = mq0.size();
        sz[1] = mq1.size();
        lim   = (&thread_active) ? HALF : DEPTH;
        for (int t = 0; t < 2; t++) begin
            e_full[t] = !thread_active[t] || sz[t] >= lim || (sz[0] + sz[1]) >= DEPTH;
            hs[t]     = sz[t] > 0 && !flush[t];
        end
        e_valid = |hs;
        e_tid   = (hs[0] && hs[1]) ? ~m_last : hs[1];
        chk("full", 32'(full), 32'(e_full));
        chk("empty", 32'(empty), {30'd0, sz[1] == 0, sz[0] == 0});
        chk("deq_valid", 32'(deq_valid), 32'(e_valid));
        if (e_valid) begin
            ed = e_tid ? mq1[0] : mq0[0];
            chk("deq_tid", 32'(deq_tid), 32'(e_tid));
            chk("deq_data", 32'(deq_data), 32'(ed));
        end
    endtask

    task automatic advance();
        #1 compare();
        @(posedge clk);
        if (deq_req && e_valid) begin
            if (e_tid) void'(mq1.pop_front());
            else       void'(mq0.pop_front());
            m_last = e_tid;
        end
        if (flush[0]) mq0.delete();
        if (flush[1]) mq1.delete();
        if (enq_valid[0] && !e_full[0] && !flush[0]) mq0.push_back(enq_data[0]);
        if (enq_valid[1] && !e_full[1] && !flush[1]) mq1.push_back(enq_data[1]);
        @(negedge clk);
    endtask

    task automatic cyc(logic [1:0] act, logic [1:0] ev, logic [1:0] fl, logic dq);
        thread_active = act;
        enq_valid     = ev;
        flush         = fl;
        deq_req       = dq;
        for (int t = 0; t < 2; t++) begin
            enq_data[t] = DATA_W'(t * 2048 + seq);
            seq = (seq + 1) % 2048;
        end
        advance();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total_checks, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; thread_active = 2'b00; enq_valid = 2'b00;
        enq_data = '0; flush = 2'b00; deq_req = 1'b0; m_last = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        thread_active = 2'b11;
        #1;
        cur_req = "R1";
        chk("empty", 32'(empty), 32'h3);
        chk("deq_valid", 32'(deq_valid), 32'h0);
        chk("full", 32'(full), 32'h0);
        @(negedge clk);

        cur_req = "R11";
        cyc(2'b11, 2'b11, 2'b00, 1'b0);
        chk("empty", 32'(empty), 32'h0);
        cur_req = "R2";
        repeat (5) cyc(2'b11, 2'b11, 2'b00, 1'b0);
        chk("full", 32'(full), 32'h3);

        cur_req = "R6";
        repeat (5) cyc(2'b11, 2'b00, 2'b00, 1'b1);

        cur_req = "R9";
        cyc(2'b11, 2'b01, 2'b01, 1'b1);
        chk("empty", 32'(empty[0]), 32'h1);

        cur_req = "R8";
        repeat (3) cyc(2'b11, 2'b11, 2'b00, 1'b0);
        cyc(2'b11, 2'b00, 2'b10, 1'b0);
        chk("empty", 32'(empty), 32'h2);
        cur_req = "R5";
        repeat (4) cyc(2'b11, 2'b00, 2'b00, 1'b1);

        cur_req = "R7";
        repeat (2) cyc(2'b11, 2'b00, 2'b00, 1'b1);
        chk("deq_valid", 32'(deq_valid), 32'h0);

        cur_req = "R3";
        repeat (10) cyc(2'b01, 2'b01, 2'b00, 1'b0);
        chk("full", 32'(full[0]), 32'h1);

        cur_req = "R4";
        repeat (3) cyc(2'b10, 2'b11, 2'b00, 1'b0);
        chk("full", 32'(full), 32'h3);
        chk("empty", 32'(empty[0]), 32'h0);

        cur_req = "R10";
        repeat (5) cyc(2'b11, 2'b01, 2'b00, 1'b1);
        repeat (4) cyc(2'b11, 2'b11, 2'b00, 1'b0);

        cur_req = "R5";
        for (int k = 0; k < 600; k++) begin
            logic [1:0] a;
            logic [1:0] f;
            a = ($urandom % 4 == 0) ? 2'($urandom) : 2'b11;
            f = ($urandom % 12 == 0) ? 2'($urandom) : 2'b00;
            cyc(a, 2'($urandom), f, 1'($urandom));
        end
        cur_req = "R7";
        repeat (2 * DEPTH + 2) cyc(2'b11, 2'b00, 2'b00, 1'b1);
        chk("empty", 32'(empty), 32'h3);

        $display("  test done: total=%0d bad=%0d", total_checks, bad);
        $finish;
    end
endmodule